// File: doc/BRIEF.md
# Committing Two-Phase-Code Transfer Sender

This block is the sending end of a point-to-point rendezvous link. Local logic asks it to move one data word. The block then runs a fixed exchange with a remote receiver over a 2-bit request code, a 2-bit acknowledge code and a data bus. The exchange has four steps: announce the offer, present the word, collect the receiver's verdict, and settle the outcome. It settles the outcome by the final code it places on the request lines.

The sender always has the last word. The receiver can take the word, but the local side can still void the transfer by raising its abort input at any point from the offer up to the verdict cycle. In that case the sender drives the discard code even though the receiver accepted. Local logic sees a single-cycle completion strobe, and exactly one of a commit or an abort flag rises with it.

Codes on the request lines: 00 idle and data-present, 01 offer, 10 commit, 11 discard. Codes on the acknowledge lines: 00 idle, 01 ready, 10 take, 11 refuse.

Top module: `hs_commit_sender`

## Requirements
- R1: After reset the request code is 00 and `done`, `committed` and `aborted` are all 0.
- R2: A `send_req` seen while idle and while the acknowledge code is 00 makes the request code 01 on the next cycle. It stays 01 until the acknowledge code is 01.
- R3: One cycle after the acknowledge code reads 01 in the offer step, the request code becomes 00 and `data_out` carries the word captured with the send. It stays there while the acknowledge code is neither 10 nor 11.
- R4: When the acknowledge code reads 10 during the data step and no local abort is pending, the next cycle shows request code 10 with `done` and `committed` high.
- R5: When the acknowledge code reads 11 during the data step, the next cycle shows request code 11 with `done` and `aborted` high.
- R6: An `abort_req` high in any cycle from the offer step up to and including the verdict cycle forces request code 11 and `aborted`, even after acknowledge 10. An `abort_req` while idle has no effect on the next exchange.
- R7: `data_out` holds the captured word unchanged from the data step through the final step. Changes on `send_data` after the capture are ignored.
- R8: `done` is high for exactly one cycle per exchange, and exactly one of `committed` or `aborted` is high with it. Both are low whenever `done` is low.
- R9: The final code is held one cycle, and then the request code returns to 00. A new send is refused while the acknowledge code is not 00, and `send_req` during an exchange is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| send_req | input | 1 | Local request to transfer `send_data` |
| send_data | input | DATA_W | Word to transfer, captured when the send is accepted |
| abort_req | input | 1 | Local cancel, honoured from the offer step until the verdict |
| ack_code | input | 2 | Acknowledge code from the receiver |
| req_code | output | 2 | Request code to the receiver |
| data_out | output | DATA_W | Data bus to the receiver |
| done | output | 1 | One-cycle completion strobe |
| committed | output | 1 | Transfer took effect (valid with `done`) |
| aborted | output | 1 | Transfer discarded (valid with `done`) |

## Verification
The hardest case to reach is the sender overruling a receiver that has already accepted. This needs a local abort that arrives early and is kept, then an acknowledge of 10 several cycles later. The vector table pairs abort with a take verdict, and a directed test pulses the abort while the sender is still waiting on the ready code. A further directed test leaves the acknowledge at its verdict value after completion, to show that new sends are held off.

// File: rtl/hs_sender_pkg.sv
package hs_sender_pkg;

    localparam int CODE_W = 2;

    localparam logic [CODE_W-1:0] REQ_IDLE    = 2'b00;
    localparam logic [CODE_W-1:0] REQ_OFFER   = 2'b01;
    localparam logic [CODE_W-1:0] REQ_PRESENT = 2'b00;
    localparam logic [CODE_W-1:0] REQ_COMMIT  = 2'b10;
    localparam logic [CODE_W-1:0] REQ_DISCARD = 2'b11;

    localparam logic [CODE_W-1:0] ACK_IDLE   = 2'b00;
    localparam logic [CODE_W-1:0] ACK_READY  = 2'b01;
    localparam logic [CODE_W-1:0] ACK_TAKE   = 2'b10;
    localparam logic [CODE_W-1:0] ACK_REFUSE = 2'b11;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_OFFER   = 2'd1,
        PH_PRESENT = 2'd2,
        PH_FINAL   = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   verdict_ok;
        logic   abort_pend;
    } fsm_state_t;

endpackage

// File: rtl/hs_phase_fsm.sv
module hs_phase_fsm
    import hs_sender_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              send_req,
    input  logic              abort_req,
    input  logic [CODE_W-1:0] ack_code,
    output phase_e            phase,
    output logic              verdict_ok,
    output logic              capture
);

    fsm_state_t st_d, st_q;
    logic       cap_d;

    always_comb begin
        st_d  = st_q;
        cap_d = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                st_d.abort_pend = 1'b0;
                if (send_req && (ack_code == ACK_IDLE)) begin
                    st_d.phase      = PH_OFFER;
                    st_d.verdict_ok = 1'b0;
                    cap_d           = 1'b1;
                end
            end
            PH_OFFER: begin
                if (abort_req) begin
                    st_d.abort_pend = 1'b1;
                end
                if (ack_code == ACK_READY) begin
                    st_d.phase = PH_PRESENT;
                end
            end
            PH_PRESENT: begin
                if (abort_req) begin
                    st_d.abort_pend = 1'b1;
                end
                if ((ack_code == ACK_TAKE) || (ack_code == ACK_REFUSE)) begin
                    st_d.phase      = PH_FINAL;
                    st_d.verdict_ok = (ack_code == ACK_TAKE) &&
                                      !st_q.abort_pend && !abort_req;
                end
            end
            PH_FINAL: begin
                st_d.phase      = PH_IDLE;
                st_d.abort_pend = 1'b0;
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, verdict_ok: 1'b0, abort_pend: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase      = st_q.phase;
    assign verdict_ok = st_q.verdict_ok;
    assign capture    = cap_d;

endmodule

// File: rtl/hs_data_hold.sv
module hs_data_hold #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (capture) begin
            word_d = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign dout = word_q;

endmodule

// File: rtl/hs_code_encoder.sv
module hs_code_encoder
    import hs_sender_pkg::*;
(
    input  phase_e            phase,
    input  logic              verdict_ok,
    output logic [CODE_W-1:0] req_code,
    output logic              done,
    output logic              committed,
    output logic              aborted
);

    always_comb begin
        req_code  = REQ_IDLE;
        done      = 1'b0;
        committed = 1'b0;
        aborted   = 1'b0;
        case (phase)
            PH_IDLE:    req_code = REQ_IDLE;
            PH_OFFER:   req_code = REQ_OFFER;
            PH_PRESENT: req_code = REQ_PRESENT;
            PH_FINAL: begin
                done      = 1'b1;
                committed = verdict_ok;
                aborted   = !verdict_ok;
                req_code  = verdict_ok ? REQ_COMMIT : REQ_DISCARD;
            end
            default:    req_code = REQ_IDLE;
        endcase
    end

endmodule

// File: rtl/hs_commit_sender.sv
module hs_commit_sender
    import hs_sender_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              send_req,
    input  logic [DATA_W-1:0] send_data,
    input  logic              abort_req,
    input  logic [1:0]        ack_code,
    output logic [1:0]        req_code,
    output logic [DATA_W-1:0] data_out,
    output logic              done,
    output logic              committed,
    output logic              aborted
);

    phase_e phase;
    logic   verdict_ok;
    logic   capture;

    hs_phase_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .send_req   (send_req),
        .abort_req  (abort_req),
        .ack_code   (ack_code),
        .phase      (phase),
        .verdict_ok (verdict_ok),
        .capture    (capture)
    );

    hs_data_hold #(.DATA_W(DATA_W)) i_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .din     (send_data),
        .dout    (data_out)
    );

    hs_code_encoder i_enc (
        .phase      (phase),
        .verdict_ok (verdict_ok),
        .req_code   (req_code),
        .done       (done),
        .committed  (committed),
        .aborted    (aborted)
    );

endmodule

// File: rtl/hs_sender_checker.sv
module hs_sender_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              send_req,
    input logic [DATA_W-1:0] send_data,
    input logic              abort_req,
    input logic [1:0]        ack_code,
    input logic [1:0]        req_code,
    input logic [DATA_W-1:0] data_out,
    input logic              done,
    input logic              committed,
    input logic              aborted
);

    logic unused_in;
    assign unused_in = send_req ^ abort_req ^ (^send_data);

    p_offer_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_code == 2'b01 && ack_code != 2'b01) |=> (req_code == 2'b01));

    p_verdict_seen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(ack_code) == 2'b10 || $past(ack_code) == 2'b11));

    p_commit_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        committed |-> (req_code == 2'b10 && $past(ack_code) == 2'b10));

    p_refuse_aborts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(ack_code) == 2'b11) |-> (aborted && req_code == 2'b11));

    p_data_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $stable(data_out));

    p_flag_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones({committed, aborted}) == 1));

    p_flags_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (!committed && !aborted));

    p_return_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (req_code == 2'b00 && !done));

endmodule

bind hs_commit_sender hs_sender_checker #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_hs_commit_sender.sv
`timescale 1ns/1ps
module test_hs_commit_sender;

    localparam int DW = 16;

    typedef struct packed {
        logic [DW-1:0] data;
        logic [3:0]    rdy_wait;
        logic [1:0]    verdict;
        logic          abort;
        logic          exp_commit;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{16'hA5A5, 4'd0, 2'b10, 1'b0, 1'b1},
        '{16'h1234, 4'd2, 2'b11, 1'b0, 1'b0},
        '{16'hFFFF, 4'd1, 2'b10, 1'b1, 1'b0},
        '{16'h0000, 4'd3, 2'b11, 1'b1, 1'b0},
        '{16'h8001, 4'd0, 2'b10, 1'b0, 1'b1},
        '{16'h5A5A, 4'd5, 2'b10, 1'b0, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          send_req = 1'b0;
    logic [DW-1:0] send_data = '0;
    logic          abort_req = 1'b0;
    logic [1:0]    ack_code = 2'b00;
    logic [1:0]    req_code;
    logic [DW-1:0] data_out;
    logic          done, committed, aborted;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    hs_commit_sender #(.DATA_W(DW)) i_hs_commit_sender (
        .clk(clk), .rst_n(rst_n), .send_req(send_req), .send_data(send_data),
        .abort_req(abort_req), .ack_code(ack_code), .req_code(req_code),
        .data_out(data_out), .done(done), .committed(committed), .aborted(aborted)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic run_xfer(input vec_t v);
        step();
        send_req = 1'b1; send_data = v.data; ack_code = 2'b00;
        step();
        send_req = 1'b0;
        chk({30'd0, req_code}, 32'h1, "R2 offer code");
        for (int k = 0; k < int'(v.rdy_wait); k++) begin
            step();
            chk({30'd0, req_code}, 32'h1, "R2 offer held");
        end
        ack_code = 2'b01;
        step();
        chk({30'd0, req_code}, 32'h0, "R3 data code");
        chk({16'd0, data_out}, {16'd0, v.data}, "R3 data bus");
        send_data = ~v.data;
        step();
        chk({30'd0, req_code}, 32'h0, "R3 waits for verdict");
        chk({16'd0, data_out}, {16'd0, v.data}, "R7 data ignores send_data");
        ack_code = v.verdict; abort_req = v.abort;
        step();
        abort_req = 1'b0;
        chk({30'd0, req_code}, v.exp_commit ? 32'h2 : 32'h3, "R4/R5/R6 final code");
        chk({29'd0, done, committed, aborted}, v.exp_commit ? 32'h6 : 32'h5, "R8 flags");
        chk({16'd0, data_out}, {16'd0, v.data}, "R7 data held at final");
        step();
        chk({29'd0, req_code, done}, 32'h0, "R9 back to idle, R8 single strobe");
        ack_code = 2'b00;
        step();
    endtask

    initial begin
        #100000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        step();
        chk({27'd0, req_code, done, committed, aborted}, 32'h0, "R1 reset state");
        step();
        rst_n = 1'b1;
        step();
        chk({27'd0, req_code, done, committed, aborted}, 32'h0, "R1 idle after reset");

        for (int i = 0; i < NV; i++) begin
            run_xfer(VECS[i]);
        end

        // R6: abort in idle has no effect on the following exchange
        abort_req = 1'b1;
        step();
        step();
        abort_req = 1'b0;
        run_xfer('{16'h3C3C, 4'd1, 2'b10, 1'b0, 1'b1});

        // R6: abort pulse early in the offer step is remembered until the verdict
        send_req = 1'b1; send_data = 16'h7777;
        step();
        send_req = 1'b0; abort_req = 1'b1;
        step();
        abort_req = 1'b0;
        step();
        ack_code = 2'b01;
        step();
        ack_code = 2'b10;
        step();
        chk({30'd0, req_code}, 32'h3, "R6 sticky abort overrides take");
        chk({30'd0, committed, aborted}, 32'h1, "R6 aborted flag");
        step();

        // R9: send refused while ack not idle
        send_req = 1'b1;
        for (int k = 0; k < 3; k++) begin
            step();
            chk({30'd0, req_code}, 32'h0, "R9 send blocked by busy ack");
        end
        ack_code = 2'b00;
        step();
        chk({30'd0, req_code}, 32'h1, "R9 send accepted after ack idle");
        send_req = 1'b1;
        step();
        chk({30'd0, req_code}, 32'h1, "R9 send_req ignored mid-exchange");

        // R1: reset in mid exchange
        rst_n = 1'b0; send_req = 1'b0;
        #1;
        chk({27'd0, req_code, done, committed, aborted}, 32'h0, "R1 reset mid exchange");
        step();
        rst_n = 1'b1;
        step();
        chk({30'd0, req_code}, 32'h0, "R1 stays idle");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule